// File: doc/BRIEF.md
# Serial LED Expander Shift Controller

This block extends a chip's output count by driving a chain of serial-in parallel-out shift register stages through two wires: a serial clock and a serial data line. Seventeen extra outputs are carried per frame. Each frame shifts the bit for the highest pin first, so that when the frame ends pin 0 sits in the first stage of the external chain.

There are two ways to fill a frame. In direct mode, software writes a 17-bit output word, and the write starts a frame at once. In waveform mode, each pin takes its level from one of eight waveform generator inputs, as chosen by a 4-bit field for that pin. A new frame goes out whenever the composed vector differs from the last one shifted. An all-zero vector is held back until a non-zero vector has been seen in that mode. The serial clock rate comes from an encoded divider. The delay from a data change to the next rising clock edge is programmable and is clamped to a safe bound. A busy flag covers each frame, and while it is set, writes to the output word and to the mode register are dropped.

Top module: `sipo_expander`

## Requirements
- R1: With waveform mode off and no frame in progress, a write to address 0 stores wr_data[16:0] and starts a frame of exactly 17 rising serial-clock edges. The bit for pin 16 is sent first and pin 0 last. Reading address 0 returns the stored word in bits 16:0 and the busy flag in bit 31.
- R2: The divider field (address 1, bits 1:0) sets the number of internal clocks between successive rising serial-clock edges: code 0 gives 4, 1 gives 8, 2 gives 16 and 3 gives 32.
- R3: The data line changes only while the serial clock is low. Each rising edge comes (delay + 1) internal clocks after the data change for that bit. The first data bit appears in the first cycle that busy is high.
- R4: The delay register (address 2, bits 4:0) applies as programmed up to half the divisor minus one. Larger values act as that limit, which is 1 for /4, 3 for /8, 7 for /16 and 15 for /32.
- R5: Busy stays high for 16*divisor + delay + 2 internal clocks and clears one clock after the last rising edge. The serial clock is low whenever busy is low.
- R6: While busy is high, writes to address 0 (output word) and address 3 (mode) are ignored. They start no frame and leave the read-back value unchanged.
- R7: In the mode register (address 3), bit 1 enables waveform mode and bit 0 holds the alternate chain variant select. Both read back as written.
- R8: The mapping fields for pin p sit in the word at address 4 + p/8, in bits 4*(p%8)+3 down to 4*(p%8). Field bit 3 enables the pin and field bits 2:0 select a generator. In waveform mode the pin's bit equals the selected generator input when enabled, and 0 when disabled.
- R9: In waveform mode, a frame starts when the composed vector differs from the last vector shifted. No frame starts while they are equal. An all-zero vector starts no frame until a non-zero vector has been seen since waveform mode was entered.
- R10: In waveform mode, a write to address 0 while idle stores the word but starts no frame.
- R11: After reset, busy, the serial clock, the serial data line, the output word and the mode register are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 3 | Register read address |
| rd_data | output | 32 | Register read data (combinational) |
| gen_wave | input | 8 | Waveform generator levels |
| ser_clk | output | 1 | Serial clock to the external chain |
| ser_dat | output | 1 | Serial data to the external chain |
| busy | output | 1 | High while a frame is being shifted |

## Verification
The assertions assume that the generator levels and the register port are synchronous to the internal clock and change only at its edges. They also assume that the divider and delay values in force for a frame are the values captured when that frame starts. The stimulus therefore drives every input half a cycle away from the active edge. It changes the generator vector only between frames, and it programs the divider and delay before starting each frame. The table rows use delays at and beyond the clamp limit, so the clamping path is covered under the same assumptions.

// File: rtl/sipo_exp_pkg.sv
package sipo_exp_pkg;
   // mapping field layout shared by all pins
   localparam int unsigned FIELD_W       = 4;
   localparam int unsigned SEL_W         = 3;
   localparam int unsigned PINS_PER_WORD = 8;
   localparam int unsigned REG_W         = 32;
   localparam int unsigned BUSY_BIT      = 31;
   localparam int unsigned MODE_PWM_BIT  = 1;
   localparam int unsigned MODE_ALT_BIT  = 0;
   // register addresses
   localparam int unsigned A_DATA = 0;
   localparam int unsigned A_DIV  = 1;
   localparam int unsigned A_DLY  = 2;
   localparam int unsigned A_MODE = 3;
   localparam int unsigned A_MAP  = 4;
endpackage

// File: rtl/sipo_exp_regs.sv
module sipo_exp_regs
   import sipo_exp_pkg::*;
#(
   parameter int unsigned NUM_PINS = 17,
   parameter int unsigned DIV_W    = 2,
   parameter int unsigned DLY_W    = 5,
   parameter int unsigned ADDR_W   = 3
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        wr_en,
   input  logic [ADDR_W-1:0]           wr_addr,
   input  logic [REG_W-1:0]            wr_data,
   input  logic [ADDR_W-1:0]           rd_addr,
   input  logic                        busy,
   output logic [NUM_PINS-1:0]         data_q,
   output logic [DIV_W-1:0]            div_q,
   output logic [DLY_W-1:0]            dly_q,
   output logic                        mode_pwm,
   output logic                        mode_alt,
   output logic [NUM_PINS*FIELD_W-1:0] map_q,
   output logic                        data_acc,
   output logic [REG_W-1:0]            rd_data
);
   logic mode_acc;

   assign data_acc = wr_en && !busy && (wr_addr == ADDR_W'(A_DATA));
   assign mode_acc = wr_en && !busy && (wr_addr == ADDR_W'(A_MODE));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         data_q   <= '0;
         div_q    <= '0;
         dly_q    <= '0;
         mode_pwm <= 1'b0;
         mode_alt <= 1'b0;
         map_q    <= '0;
      end else begin
         if (data_acc) data_q <= wr_data[NUM_PINS-1:0];
         if (mode_acc) begin
            mode_pwm <= wr_data[MODE_PWM_BIT];
            mode_alt <= wr_data[MODE_ALT_BIT];
         end
         if (wr_en && wr_addr == ADDR_W'(A_DIV)) div_q <= wr_data[DIV_W-1:0];
         if (wr_en && wr_addr == ADDR_W'(A_DLY)) dly_q <= wr_data[DLY_W-1:0];
         for (int p = 0; p < NUM_PINS; p++) begin
            if (wr_en && wr_addr == ADDR_W'(A_MAP + p / PINS_PER_WORD))
               map_q[p*FIELD_W +: FIELD_W] <= wr_data[(p % PINS_PER_WORD)*FIELD_W +: FIELD_W];
         end
      end
   end

   always_comb begin
      rd_data = '0;
      if (rd_addr == ADDR_W'(A_DATA)) begin
         rd_data[NUM_PINS-1:0] = data_q;
         rd_data[BUSY_BIT]     = busy;
      end
      if (rd_addr == ADDR_W'(A_DIV))  rd_data[DIV_W-1:0] = div_q;
      if (rd_addr == ADDR_W'(A_DLY))  rd_data[DLY_W-1:0] = dly_q;
      if (rd_addr == ADDR_W'(A_MODE)) begin
         rd_data[MODE_PWM_BIT] = mode_pwm;
         rd_data[MODE_ALT_BIT] = mode_alt;
      end
      for (int p = 0; p < NUM_PINS; p++) begin
         if (rd_addr == ADDR_W'(A_MAP + p / PINS_PER_WORD))
            rd_data[(p % PINS_PER_WORD)*FIELD_W +: FIELD_W] = map_q[p*FIELD_W +: FIELD_W];
      end
   end
endmodule

// File: rtl/sipo_exp_compose.sv
module sipo_exp_compose
   import sipo_exp_pkg::*;
#(
   parameter int unsigned NUM_PINS = 17,
   parameter int unsigned NUM_GEN  = 8
) (
   input  logic [NUM_PINS*FIELD_W-1:0] map_q,
   input  logic [NUM_GEN-1:0]          gen_wave,
   output logic [NUM_PINS-1:0]         pin_vec
);
   localparam int unsigned SEL_SPAN = 1 << SEL_W;

   logic [SEL_SPAN-1:0] gen_ext;

   always_comb begin
      gen_ext              = '0;
      gen_ext[NUM_GEN-1:0] = gen_wave;
   end

   for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
      logic             pin_en;
      logic [SEL_W-1:0] pin_sel;
      assign pin_en     = map_q[p*FIELD_W + FIELD_W - 1];
      assign pin_sel    = map_q[p*FIELD_W +: SEL_W];
      assign pin_vec[p] = pin_en & gen_ext[pin_sel];
   end
endmodule

// File: rtl/sipo_exp_shifter.sv
module sipo_exp_shifter #(
   parameter int unsigned NUM_PINS = 17,
   parameter int unsigned DIV_W    = 2,
   parameter int unsigned DLY_W    = 5,
   parameter int unsigned CNT_W    = 7
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [NUM_PINS-1:0] load,
   input  logic [DIV_W-1:0]    div,
   input  logic [DLY_W-1:0]    dly,
   output logic                busy,
   output logic                sclk,
   output logic                sdo
);
   localparam int unsigned BIT_W = $clog2(NUM_PINS);
   localparam logic [BIT_W-1:0] LAST_BIT = BIT_W'(NUM_PINS - 1);

   logic [CNT_W-1:0]    divisor, half, half_m1, eff_dly;
   logic                busy_q;
   logic [CNT_W-1:0]    cnt_q, top_q, rise_q, hi_end_q;
   logic [BIT_W-1:0]    bit_q;
   logic [NUM_PINS-1:0] sh_q;

   always_comb begin
      divisor = CNT_W'(4) << div;
      half    = divisor >> 1;
      half_m1 = half - 1'b1;
      eff_dly = (CNT_W'(dly) > half_m1) ? half_m1 : CNT_W'(dly);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy_q   <= 1'b0;
         cnt_q    <= '0;
         top_q    <= '0;
         rise_q   <= '0;
         hi_end_q <= '0;
         bit_q    <= '0;
         sh_q     <= '0;
      end else if (!busy_q) begin
         if (start) begin
            busy_q   <= 1'b1;
            cnt_q    <= '0;
            bit_q    <= '0;
            sh_q     <= load;
            top_q    <= divisor - 1'b1;
            rise_q   <= eff_dly + 1'b1;
            hi_end_q <= eff_dly + half;
         end
      end else if (bit_q == LAST_BIT && cnt_q == rise_q) begin
         busy_q <= 1'b0;
      end else if (cnt_q == top_q) begin
         cnt_q <= '0;
         bit_q <= bit_q + 1'b1;
         sh_q  <= {sh_q[NUM_PINS-2:0], 1'b0};
      end else begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   assign busy = busy_q;
   assign sclk = busy_q && (cnt_q >= rise_q) && (cnt_q <= hi_end_q);
   assign sdo  = busy_q & sh_q[NUM_PINS-1];
endmodule

// File: rtl/sipo_expander.sv
module sipo_expander
   import sipo_exp_pkg::*;
#(
   parameter int unsigned NUM_PINS = 17,
   parameter int unsigned NUM_GEN  = 8,
   parameter int unsigned DIV_W    = 2,
   parameter int unsigned DLY_W    = 5,
   localparam int unsigned MAP_WORDS = (NUM_PINS + PINS_PER_WORD - 1) / PINS_PER_WORD,
   localparam int unsigned ADDR_W    = $clog2(A_MAP + MAP_WORDS),
   localparam int unsigned CNT_W     = 3 + (1 << DIV_W)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [REG_W-1:0]  wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [REG_W-1:0]  rd_data,
   input  logic [NUM_GEN-1:0] gen_wave,
   output logic              ser_clk,
   output logic              ser_dat,
   output logic              busy
);
   // elaboration-time parameter checks
   if (NUM_PINS < 2 || NUM_PINS > BUSY_BIT) begin : g_bad_pins
      $error("NUM_PINS must lie in 2..31");
   end
   if (NUM_GEN < 1 || NUM_GEN > (1 << SEL_W)) begin : g_bad_gen
      $error("NUM_GEN must lie in 1..8");
   end
   if (DIV_W < 1 || DIV_W > 3) begin : g_bad_div
      $error("DIV_W must lie in 1..3");
   end
   if (DLY_W > CNT_W) begin : g_bad_dly
      $error("DLY_W must not exceed the frame counter width");
   end

   logic [NUM_PINS-1:0]         data_q, pin_vec, last_q, load;
   logic [DIV_W-1:0]            div_q;
   logic [DLY_W-1:0]            dly_q;
   logic                        mode_pwm, mode_alt, data_acc;
   logic [NUM_PINS*FIELD_W-1:0] map_q;
   logic                        armed_q, vec_nz, pwm_go, start;

   sipo_exp_regs #(
      .NUM_PINS(NUM_PINS), .DIV_W(DIV_W), .DLY_W(DLY_W), .ADDR_W(ADDR_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .busy(busy),
      .data_q(data_q), .div_q(div_q), .dly_q(dly_q),
      .mode_pwm(mode_pwm), .mode_alt(mode_alt), .map_q(map_q),
      .data_acc(data_acc), .rd_data(rd_data)
   );

   sipo_exp_compose #(
      .NUM_PINS(NUM_PINS), .NUM_GEN(NUM_GEN)
   ) i_compose (
      .map_q(map_q), .gen_wave(gen_wave), .pin_vec(pin_vec)
   );

   // frame trigger: direct writes in direct mode, vector changes in waveform mode
   assign vec_nz = |pin_vec;
   assign pwm_go = mode_pwm && (pin_vec != last_q) && (armed_q || vec_nz);
   assign start  = !busy && ((data_acc && !mode_pwm) || pwm_go);
   assign load   = mode_pwm ? pin_vec : wr_data[NUM_PINS-1:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         last_q  <= '0;
         armed_q <= 1'b0;
      end else begin
         if (start) last_q <= load;
         armed_q <= mode_pwm ? (armed_q | vec_nz) : 1'b0;
      end
   end

   sipo_exp_shifter #(
      .NUM_PINS(NUM_PINS), .DIV_W(DIV_W), .DLY_W(DLY_W), .CNT_W(CNT_W)
   ) i_shifter (
      .clk(clk), .rst_n(rst_n), .start(start), .load(load),
      .div(div_q), .dly(dly_q), .busy(busy), .sclk(ser_clk), .sdo(ser_dat)
   );
endmodule

// File: rtl/sipo_exp_chk.sv
module sipo_exp_chk #(
   parameter int unsigned NUM_PINS = 17,
   parameter int unsigned ADDR_W   = 3
) (
   input logic                clk,
   input logic                rst_n,
   input logic                busy,
   input logic                sclk,
   input logic                sdo,
   input logic                pwm_en,
   input logic                mode_alt,
   input logic [NUM_PINS-1:0] data_q,
   input logic                wr_en,
   input logic [ADDR_W-1:0]   wr_addr,
   input logic [NUM_PINS-1:0] vec,
   input logic [NUM_PINS-1:0] last_q,
   input logic                armed
);
   AST_SDO_HOLD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk && $past(sclk)) |-> $stable(sdo)); // R3
   AST_RISE_NOT_AT_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !sclk); // R3
   AST_IDLE_CLOCK_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !sclk); // R5
   AST_DATA_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> $stable(data_q)); // R6
   AST_MODE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(pwm_en) && $stable(mode_alt))); // R6
   AST_DIRECT_STARTS: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !pwm_en && wr_en && wr_addr == '0) |=> busy); // R1
   AST_PWM_QUIET_EQUAL: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && pwm_en && vec == last_q) |=> !busy); // R9
   AST_PWM_ZERO_UNARMED: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && pwm_en && !armed && vec == '0) |=> !busy); // R9
endmodule

bind sipo_expander sipo_exp_chk #(
   .NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)
) i_chk (
   .clk(clk), .rst_n(rst_n), .busy(busy), .sclk(ser_clk), .sdo(ser_dat),
   .pwm_en(mode_pwm), .mode_alt(mode_alt), .data_q(data_q),
   .wr_en(wr_en), .wr_addr(wr_addr), .vec(pin_vec), .last_q(last_q),
   .armed(armed_q)
);

// File: tb/test_sipo_expander.sv
`timescale 1ns/1ps
module test_sipo_expander;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_addr = '0;
   logic [31:0] wr_data = '0;
   logic [2:0]  rd_addr = '0;
   logic [31:0] rd_data;
   logic [7:0]  gen_wave = '0;
   logic        ser_clk, ser_dat, busy;

   int checks = 0;
   int errors = 0;

   always #10 clk = ~clk;

   sipo_expander i_sipo_expander (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
      .gen_wave(gen_wave), .ser_clk(ser_clk), .ser_dat(ser_dat), .busy(busy)
   );

   // stimulus and expected results: divider code, delay, word, expected divisor, effective delay
   typedef struct packed {
      logic [1:0]  div;
      logic [4:0]  dly;
      logic [16:0] word;
      logic [5:0]  exp_div;
      logic [4:0]  exp_dly;
   } row_t;
   localparam row_t ROWS [6] = '{
      '{2'd0, 5'd0,  17'h1A5A5, 6'd4,  5'd0},
      '{2'd1, 5'd3,  17'h00001, 6'd8,  5'd3},
      '{2'd2, 5'd7,  17'h10000, 6'd16, 5'd7},
      '{2'd3, 5'd15, 17'h15555, 6'd32, 5'd15},
      '{2'd0, 5'd5,  17'h0AAAA, 6'd4,  5'd1},
      '{2'd1, 5'd9,  17'h1FFFF, 6'd8,  5'd3}
   };

   // serial line monitor, sampled on the falling edge
   int          starts = 0, frames = 0, nb = 0, np = 0, frise = 0, prise = 0, gap = 0;
   int          f_np = 0, f_len = 0, fmark = 0;
   logic [16:0] cap = '0, f_cap = '0;
   logic        pb = 1'b0, pc = 1'b0;

   always @(negedge clk) begin
      if (busy && !pb) begin
         nb = 0; np = 0; cap = '0; starts++;
      end
      if (busy) nb++;
      if (ser_clk && !pc) begin
         cap = {cap[15:0], ser_dat};
         if (np == 0) frise = nb - 1;
         else gap = (nb - 1) - prise;
         prise = nb - 1;
         np++;
      end
      if (!busy && pb) begin
         frames++; f_cap = cap; f_np = np; f_len = nb;
      end
      pb = busy;
      pc = ser_clk;
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      @(negedge clk);
      rd_addr = a;
      #1 v = rd_data;
   endtask

   task automatic wait_frame();
      for (int i = 0; i < 3000 && frames == fmark; i++) @(negedge clk);
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int s0;
      idle(3);
      // R11 reset state
      chk("R11 busy", 32'(busy), 0);
      chk("R11 ser_clk", 32'(ser_clk), 0);
      chk("R11 ser_dat", 32'(ser_dat), 0);
      rst_n = 1'b1;
      idle(2);
      rd(3'd0, v); chk("R11 data reg", v, 0);
      rd(3'd3, v); chk("R11 mode reg", v, 0);

      // table walk: direct mode frames (R1..R5)
      for (int r = 0; r < 6; r++) begin
         wr(3'd1, 32'(ROWS[r].div));
         wr(3'd2, 32'(ROWS[r].dly));
         fmark = frames;
         wr(3'd0, 32'(ROWS[r].word));
         wait_frame();
         chk("R1 frame word", 32'(f_cap), 32'(ROWS[r].word));
         chk("R1 pulse count", 32'(f_np), 17);
         chk("R2 edge spacing", 32'(gap), 32'(ROWS[r].exp_div));
         chk((ROWS[r].dly != ROWS[r].exp_dly) ? "R4 clamped delay" : "R3 rise delay",
             32'(frise), 32'(ROWS[r].exp_dly) + 1);
         chk("R5 busy length", 32'(f_len),
             16 * 32'(ROWS[r].exp_div) + 32'(ROWS[r].exp_dly) + 2);
         chk("R5 idle clock", 32'(ser_clk), 0);
      end

      // R1 busy bit and R6 gating while a frame runs
      wr(3'd1, 32'd1);
      wr(3'd2, 32'd0);
      fmark = frames;
      s0 = starts;
      wr(3'd0, 32'h0F00F);
      rd(3'd0, v);
      chk("R1 busy bit", v, 32'h8000F00F);
      wr(3'd0, 32'h00FF0);
      wr(3'd3, 32'h3);
      wait_frame();
      chk("R6 frame word", 32'(f_cap), 32'h0F00F);
      idle(40);
      rd(3'd0, v); chk("R6 data kept", v, 32'h0F00F);
      rd(3'd3, v); chk("R6 mode kept", v, 0);
      chk("R6 no extra frame", 32'(starts - s0), 1);

      // R7 mode bits read back
      wr(3'd3, 32'h1);
      rd(3'd3, v); chk("R7 alt bit", v, 32'h1);
      wr(3'd3, 32'h0);

      // R8 mapping: pin0 on gen2, pin9 disabled with sel 2, pin16 on gen5
      wr(3'd0, 32'h0);
      idle(200);
      wr(3'd1, 32'd0);
      wr(3'd4, 32'h0000000A);
      wr(3'd5, 32'h00000020);
      wr(3'd6, 32'h0000000D);
      rd(3'd5, v); chk("R8 map readback", v, 32'h20);
      // leave a non-zero last word, then enter waveform mode with all-zero vector
      fmark = frames;
      wr(3'd0, 32'h00003);
      wait_frame();
      s0 = starts;
      wr(3'd3, 32'h2);
      idle(100);
      chk("R9 zero before non-zero", 32'(starts - s0), 0);

      fmark = frames;
      gen_wave = 8'h04;
      wait_frame();
      chk("R8 pin0 from gen2, pin9 off", 32'(f_cap), 32'h00001);
      fmark = frames;
      gen_wave = 8'h24;
      wait_frame();
      chk("R8 pin16 from gen5", 32'(f_cap), 32'h10001);
      s0 = starts;
      idle(100);
      chk("R9 equal vector quiet", 32'(starts - s0), 0);

      // R10 data write in waveform mode
      s0 = starts;
      wr(3'd0, 32'h1FFFF);
      idle(100);
      chk("R10 no frame", 32'(starts - s0), 0);
      rd(3'd0, v); chk("R10 word stored", v, 32'h1FFFF);

      // R9 return to zero once armed
      fmark = frames;
      gen_wave = 8'h00;
      wait_frame();
      chk("R9 zero after non-zero", 32'(frames - fmark), 1);
      chk("R9 zero frame word", 32'(f_cap), 0);

      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule